// File: doc/BRIEF.md
# Two-Layer Perceptron Inference Sequencer

This block runs one inference pass of a small two-layer perceptron. It owns a single shared multiply pipeline and a single shared accumulator. Both are time-multiplexed across every neuron of the network. After a start pulse it walks the input window pixel by pixel and fetches each pixel together with the matching preloaded weight from synchronous on-chip memories. It forms the weighted sum of each hidden neuron and passes that sum through a clamped linear stand-in for a hyperbolic tangent. The result goes into an internal scratch memory.

It then replays the scratch memory as the input vector of the single output neuron. It subtracts a programmable threshold from the network output and takes the sign of the difference as the face / non-face decision. All arithmetic is signed fixed point with `FRAC` fraction bits. The default network is a 20x20 pixel window (400 inputs), 300 hidden neurons and one output. Weights for hidden neuron j sit at word addresses j*N_IN .. j*N_IN+N_IN-1. The output neuron's weights follow at N_HID*N_IN .. N_HID*N_IN+N_HID-1.

Both memories answer one cycle after the address. No ready signal is involved: the sequencer issues one multiply per cycle and never stalls. Before each activation it waits until the multiply pipeline is empty.

Top module: `tlp_infer_seq`

## Requirements
- R1: After reset, busy, done, is_face and y_out are all 0.
- R2: A start sampled high while busy is low begins a pass, and busy is high in the next cycle.
- R3: The pre-activation acc_j of hidden neuron j is the exact sum over i of pix[i]*w[j*N_IN+i]. Here pix_addr = i, w_addr = j*N_IN+i, and both memories return data one cycle after the address.
- R4: The hidden output is h_j = clamp(floor(acc_j / 2^(FRAC+ACT_SHIFT)), -2^FRAC, +2^FRAC). This means it never leaves the range -1.0 .. +1.0.
- R5: y_out is floor(sum_j h_j*w[N_HID*N_IN+j] / 2^FRAC), saturated to the signed DW-bit range.
- R6: is_face is 1 when y_out minus threshold, formed in DW+1 bits, is non-negative. A threshold equal to the output therefore means face.
- R7: done is high for exactly one cycle, in the cycle right after y_out and is_face take their new values. busy is low in the cycle after done. Both results hold until the next pass finishes.
- R8: A start while busy is high is ignored. The running pass keeps its result and its duration.
- R9: busy stays high for exactly N_HID*(N_IN+MUL_LAT+3) + N_HID + MUL_LAT + 4 cycles per pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one inference pass when idle |
| threshold | input | DW | Signed decision threshold, FRAC fraction bits |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| pix_addr | output | $clog2(N_IN) | Pixel memory read address |
| pix_data | input | DW | Pixel word, one cycle after address |
| w_addr | output | $clog2(N_HID*N_IN+N_HID) | Weight memory read address |
| w_data | input | DW | Weight word, one cycle after address |
| y_out | output | DW | Saturated network output of the last pass |
| is_face | output | 1 | Decision of the last pass |

## Verification
Several outcomes are hard to reach with ordinary data: the hidden clamp at both rails, output saturation, and the decision at exactly zero margin. Random pixels and weights almost never drive a hidden sum past one unit or the output sum past the word range. Directed passes therefore use extreme pixel and weight values to pin every hidden neuron to +1 or -1, and large output weights to force saturation. The threshold is then set to the expected output and to one step above it. A start pulse injected halfway through a pass checks that the pass is neither restarted nor stretched.

// File: rtl/tlp_pkg.sv
package tlp_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RUN_H, S_DRAIN_H, S_ACT_H,
    S_RUN_O, S_DRAIN_O, S_DECIDE, S_FINISH
  } seq_state_t;
endpackage

// File: rtl/tlp_mac_pipe.sv
module tlp_mac_pipe #(
  parameter int DW      = 16,
  parameter int ACCW    = 40,
  parameter int MUL_LAT = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   in_valid,
  input  logic signed [DW-1:0]   in_a,
  input  logic signed [DW-1:0]   in_b,
  output logic signed [ACCW-1:0] acc,
  output logic                   busy
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod_q [MUL_LAT];
  logic [MUL_LAT-1:0]   vld_q;
  logic signed [PW-1:0] mult;

  assign mult = in_a * in_b;

  // multiplier stages: first stage computes, the rest only delay
  for (genvar k = 0; k < MUL_LAT; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prod_q[k] <= '0;
        vld_q[k]  <= 1'b0;
      end else if (k == 0) begin
        prod_q[k] <= mult;
        vld_q[k]  <= in_valid;
      end else begin
        prod_q[k] <= prod_q[(k > 0) ? k-1 : 0];
        vld_q[k]  <= vld_q[(k > 0) ? k-1 : 0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    acc <= '0;
    else if (clr)                  acc <= '0;
    else if (vld_q[MUL_LAT-1])     acc <= acc + ACCW'(prod_q[MUL_LAT-1]);
  end

  assign busy = |vld_q;
endmodule

// File: rtl/tlp_lin_act.sv
module tlp_lin_act #(
  parameter int ACCW      = 40,
  parameter int DW        = 16,
  parameter int FRAC      = 8,
  parameter int ACT_SHIFT = 1
) (
  input  logic signed [ACCW-1:0] acc,
  output logic signed [DW-1:0]   h
);
  localparam logic signed [ACCW-1:0] POS_ONE = ACCW'(1) <<< FRAC;
  localparam logic signed [ACCW-1:0] NEG_ONE = -POS_ONE;

  logic signed [ACCW-1:0] scaled;
  logic signed [ACCW-1:0] bounded;

  always_comb begin
    scaled = acc >>> (FRAC + ACT_SHIFT);
    if (scaled > POS_ONE)      bounded = POS_ONE;
    else if (scaled < NEG_ONE) bounded = NEG_ONE;
    else                       bounded = scaled;
    h = DW'(bounded);
  end
endmodule

// File: rtl/tlp_scratch.sv
module tlp_scratch #(
  parameter int DW    = 16,
  parameter int DEPTH = 300,
  parameter int AW    = 9
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic signed [DW-1:0] wdata,
  input  logic [AW-1:0]        raddr,
  output logic signed [DW-1:0] rdata
);
  logic signed [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tlp_infer_seq.sv
module tlp_infer_seq #(
  parameter int N_IN      = 400,
  parameter int N_HID     = 300,
  parameter int DW        = 16,
  parameter int FRAC      = 8,
  parameter int ACT_SHIFT = 1,
  parameter int MUL_LAT   = 2,
  localparam int W_DEPTH  = N_HID * N_IN + N_HID,
  localparam int WAW      = $clog2(W_DEPTH),
  localparam int PAW      = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [DW-1:0] threshold,
  output logic                 busy,
  output logic                 done,
  output logic [PAW-1:0]       pix_addr,
  input  logic signed [DW-1:0] pix_data,
  output logic [WAW-1:0]       w_addr,
  input  logic signed [DW-1:0] w_data,
  output logic signed [DW-1:0] y_out,
  output logic                 is_face
);
  import tlp_pkg::*;

  localparam int NMAX = (N_IN > N_HID) ? N_IN : N_HID;
  localparam int IW   = $clog2(NMAX + 1);
  localparam int HAW  = (N_HID > 1) ? $clog2(N_HID) : 1;
  localparam int ACCW = 2 * DW + IW;
  localparam logic signed [ACCW-1:0] Y_MAX = ACCW'((64'sd1 <<< (DW-1)) - 1);
  localparam logic signed [ACCW-1:0] Y_MIN = -ACCW'(64'sd1 <<< (DW-1));

  seq_state_t state;
  logic [IW-1:0]  idx;
  logic [HAW-1:0] nrn;
  logic [WAW-1:0] wbase;
  logic           issue, issue_q, out_layer, drained;
  logic           last_in, last_hid, acc_clr, hid_we, mac_busy;
  logic signed [DW-1:0]   x_sel, hid_wdata, hid_rdata;
  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] y_full;
  logic signed [DW-1:0]   y_sat;
  logic signed [DW:0]     margin;

  assign issue     = (state == S_RUN_H) || (state == S_RUN_O);
  assign out_layer = (state == S_RUN_O) || (state == S_DRAIN_O);
  assign last_in   = (idx == IW'(N_IN - 1));
  assign last_hid  = (idx == IW'(N_HID - 1));
  assign drained   = !issue_q && !mac_busy;
  assign acc_clr   = ((state == S_IDLE) && start) || (state == S_ACT_H);
  assign hid_we    = (state == S_ACT_H);
  assign pix_addr  = PAW'(idx);
  assign w_addr    = wbase + WAW'(idx);
  assign x_sel     = out_layer ? hid_rdata : pix_data;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FINISH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) issue_q <= 1'b0;
    else        issue_q <= issue;
  end

  tlp_mac_pipe #(.DW(DW), .ACCW(ACCW), .MUL_LAT(MUL_LAT)) u_mac (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .in_valid(issue_q),
    .in_a(x_sel), .in_b(w_data), .acc(acc), .busy(mac_busy)
  );

  tlp_lin_act #(.ACCW(ACCW), .DW(DW), .FRAC(FRAC), .ACT_SHIFT(ACT_SHIFT)) u_act (
    .acc(acc), .h(hid_wdata)
  );

  tlp_scratch #(.DW(DW), .DEPTH(N_HID), .AW(HAW)) u_hid (
    .clk(clk), .we(hid_we), .waddr(nrn), .wdata(hid_wdata),
    .raddr(HAW'(idx)), .rdata(hid_rdata)
  );

  always_comb begin
    y_full = acc >>> FRAC;
    if (y_full > Y_MAX)      y_sat = DW'(Y_MAX);
    else if (y_full < Y_MIN) y_sat = DW'(Y_MIN);
    else                     y_sat = DW'(y_full);
    margin = {y_sat[DW-1], y_sat} - {threshold[DW-1], threshold};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= '0;
      nrn     <= '0;
      wbase   <= '0;
      y_out   <= '0;
      is_face <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state <= S_RUN_H;
          idx   <= '0;
          nrn   <= '0;
          wbase <= '0;
        end
        S_RUN_H: begin
          if (last_in) state <= S_DRAIN_H;
          else         idx   <= idx + 1'b1;
        end
        S_DRAIN_H: if (drained) state <= S_ACT_H;
        S_ACT_H: begin
          idx   <= '0;
          wbase <= wbase + WAW'(N_IN);
          if (nrn == HAW'(N_HID - 1)) state <= S_RUN_O;
          else begin
            nrn   <= nrn + 1'b1;
            state <= S_RUN_H;
          end
        end
        S_RUN_O: begin
          if (last_hid) state <= S_DRAIN_O;
          else          idx   <= idx + 1'b1;
        end
        S_DRAIN_O: if (drained) state <= S_DECIDE;
        S_DECIDE: begin
          y_out   <= y_sat;
          is_face <= !margin[DW];
          state   <= S_FINISH;
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tlp_infer_seq_chk.sv
module tlp_infer_seq_chk #(
  parameter int N_IN  = 400,
  parameter int N_HID = 300,
  parameter int DW    = 16,
  parameter int FRAC  = 8,
  parameter int PAW   = 9,
  parameter int WAW   = 17
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 is_face,
  input logic signed [DW-1:0] y_out,
  input logic [PAW-1:0]       pix_addr,
  input logic [WAW-1:0]       w_addr,
  input logic                 hid_we,
  input logic signed [DW-1:0] hid_wdata
);
  localparam logic signed [DW-1:0] ONE_Q = DW'(1) <<< FRAC;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({is_face, y_out}) |-> done);
  // R2
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy && start) |=> busy);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy);
  // R4
  hid_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hid_we |-> (hid_wdata <= ONE_Q && hid_wdata >= -ONE_Q));
  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(pix_addr) < N_IN && int'(w_addr) < N_HID * N_IN + N_HID));
endmodule

bind tlp_infer_seq tlp_infer_seq_chk #(
  .N_IN(N_IN), .N_HID(N_HID), .DW(DW), .FRAC(FRAC), .PAW(PAW), .WAW(WAW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .is_face(is_face), .y_out(y_out), .pix_addr(pix_addr), .w_addr(w_addr),
  .hid_we(hid_we), .hid_wdata(hid_wdata)
);

// File: tb/tlp_infer_seq_tb.sv
module tlp_infer_seq_tb;
  localparam int N_IN = 6, N_HID = 4, DW = 16, FRAC = 8, ACT_SHIFT = 1, MUL_LAT = 2;
  localparam int WD  = N_HID * N_IN + N_HID;
  localparam int PAW = $clog2(N_IN);
  localparam int WAW = $clog2(WD);
  localparam int EXP_LAT = N_HID * (N_IN + MUL_LAT + 3) + N_HID + MUL_LAT + 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic signed [DW-1:0] threshold = '0;
  logic busy, done, is_face;
  logic [PAW-1:0] pix_addr;
  logic [WAW-1:0] w_addr;
  logic signed [DW-1:0] pix_data, w_data, y_out;
  logic signed [DW-1:0] pix_mem [N_IN];
  logic signed [DW-1:0] w_mem [WD];
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tlp_infer_seq #(.N_IN(N_IN), .N_HID(N_HID), .DW(DW), .FRAC(FRAC),
                  .ACT_SHIFT(ACT_SHIFT), .MUL_LAT(MUL_LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .threshold(threshold),
    .busy(busy), .done(done), .pix_addr(pix_addr), .pix_data(pix_data),
    .w_addr(w_addr), .w_data(w_data), .y_out(y_out), .is_face(is_face)
  );

  always_ff @(posedge clk) begin
    pix_data <= pix_mem[pix_addr];
    w_data   <= (int'(w_addr) < WD) ? w_mem[w_addr] : '0;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model_y();
    longint h [N_HID];
    longint a, s, y;
    for (int j = 0; j < N_HID; j++) begin
      a = 0;
      for (int i = 0; i < N_IN; i++) a += longint'(pix_mem[i]) * longint'(w_mem[j*N_IN+i]);
      s = a >>> (FRAC + ACT_SHIFT);
      if (s > 256) s = 256;
      if (s < -256) s = -256;
      h[j] = s;
    end
    a = 0;
    for (int j = 0; j < N_HID; j++) a += h[j] * longint'(w_mem[N_HID*N_IN+j]);
    y = a >>> FRAC;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return y;
  endfunction

  // one pass; inj >= 0 pulses start that many cycles into the pass
  task automatic run_pass(input longint thr, input int inj, input string tag);
    int lat, n;
    longint ey;
    bit ef;
    ey = model_y();
    ef = (ey - thr) >= 0;
    threshold = DW'(thr);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    lat = 0; n = 0;
    while (!done && n < 2000) begin
      if (busy) lat++;
      start = (n == inj);
      @(negedge clk);
      n++;
    end
    start = 0;
    if (done) lat++;
    chk(done, {tag, " R7 done seen"}, done, 1);
    chk(longint'(y_out) == ey, {tag, " R3 R5 y_out"}, y_out, ey);
    chk(is_face == ef, {tag, " R6 is_face"}, is_face, ef);
    chk(lat == EXP_LAT, {tag, " R9 R8 busy cycles"}, lat, EXP_LAT);
    @(negedge clk);
    chk(!done && !busy, {tag, " R7 pulse end"}, {done, busy}, 0);
  endtask

  task automatic fill_rand();
    for (int i = 0; i < N_IN; i++) pix_mem[i] = DW'(int'($urandom_range(1023)) - 512);
    for (int k = 0; k < WD; k++) w_mem[k] = DW'(int'($urandom_range(511)) - 256);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint y0;
    void'($urandom(32'd4242));
    for (int i = 0; i < N_IN; i++) pix_mem[i] = '0;
    for (int k = 0; k < WD; k++) w_mem[k] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !is_face && y_out == 0, "R1 reset outputs",
        {busy, done, is_face, (y_out != 0)}, 0);
    rst_n = 1;
    @(negedge clk);
    // R2 R6: zero data, zero threshold gives zero margin -> face
    run_pass(0, -1, "zero");
    // random passes with random thresholds
    for (int t = 0; t < 10; t++) begin
      fill_rand();
      run_pass(longint'(int'($urandom_range(512)) - 256), -1, "rand");
    end
    // R6 boundary: threshold equal to and one above the output
    fill_rand();
    y0 = model_y();
    run_pass(y0, -1, "thr_eq");
    run_pass(y0 + 1, -1, "thr_above");
    // R4 R5: hidden clamped at +1, output saturates high
    for (int i = 0; i < N_IN; i++) pix_mem[i] = 16'sd511;
    for (int k = 0; k < N_HID*N_IN; k++) w_mem[k] = 16'sd255;
    for (int j = 0; j < N_HID; j++) w_mem[N_HID*N_IN+j] = 16'sd32767;
    run_pass(32767, -1, "sat_hi");
    // R4 R5: hidden clamped at -1, output saturates low
    for (int k = 0; k < N_HID*N_IN; k++) w_mem[k] = -16'sd256;
    run_pass(-32767, -1, "sat_lo");
    // R4: clamp with small output weights leaves no saturation
    for (int j = 0; j < N_HID; j++) w_mem[N_HID*N_IN+j] = 16'sd100;
    run_pass(-100, -1, "clamp_lo");
    // R8: start mid-pass is ignored
    fill_rand();
    run_pass(0, 20, "restart");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule